// File: doc/BRIEF.md
# Double-Buffered PWM Channel

This block is one pulse-width modulated output driven by a 16-bit counter. Software may change the period while the waveform runs. A new period is written into a write-only staging register and held there. The running period is replaced only at the end of the current cycle, so the output never shows a cut-short or stretched cycle. Writes to the staging register are refused while either of two write-protect inputs is set. One input is the software lock and the other is the hardware lock.

The counter advances on a one-cycle enable pulse, not on a gated clock. The pulse comes from a 4-bit source code. It selects either a power-of-two tap of a free-running prescaler or one of two programmable integer dividers. The counter can count up only (left-aligned) or up then down (center-aligned). In center-aligned mode a cycle takes twice as many counter steps. The output is high while the counter is below the duty value.

Top module: `pwm_dbuf_chan`

## Requirements
- R1: A write to the staging register (address 0) does not alter the running period. The running period keeps its old value until the next cycle boundary.
- R2: Only bits 15:0 of a staging write are kept. Bits 31:16 have no effect on the stored period.
- R3: A staging write made while wp_sw_i or wp_hw_i is high is dropped. No update is applied later because of that write.
- R4: Source codes 0 to 10 give one counter step every 2^code master-clock cycles. The steps come from a free-running 10-bit prescaler, and code k fires when the prescaler's low k bits are all ones.
- R5: Source code 11 steps the counter once every DIVA cycles and code 12 once every DIVB cycles. DIVA is written at address 3 and DIVB at address 4, each 8 bits wide. A divider value of 0, or a source code of 13 to 15, stops the counter.
- R6: Left-aligned mode (config bit 4 = 0) counts 0 up to P-1 and then wraps. One output cycle is therefore P steps long, where P is the running period.
- R7: Center-aligned mode (config bit 4 = 1) counts up from 0 to P and back down to 0. One output cycle is 2×P steps long. Config bits 3:0 hold the source code, and the config register is at address 2.
- R8: The cycle boundary is the step that returns the counter to 0. At that step a pending staged value becomes the running period. If several writes arrive before the boundary, only the last one is used.
- R9: pwm_o is high when cnt_o is below the duty value (address 1, bits 15:0). It is also held high when the duty value is at or above the running period. A duty of 0 gives a constant low output.
- R10: While the running period is 0, cnt_o stays at 0 and pwm_o stays low. Every enabled step counts as a boundary in this state.
- R11: upd_o is high for one cycle after each step in which a staged value is applied, and at no other time.
- R12: After reset, the running period, staged period, duty, config, dividers, cnt_o, pwm_o and upd_o are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register address: 0 staging period, 1 duty, 2 config, 3 DIVA, 4 DIVB |
| wr_data_i | input | 32 | Write data |
| wp_sw_i | input | 1 | Software write lock for the staging register |
| wp_hw_i | input | 1 | Hardware write lock for the staging register |
| pwm_o | output | 1 | Waveform output |
| cnt_o | output | 16 | Channel counter value |
| upd_o | output | 1 | Pulses after a staged period is applied |

## Verification
The bench writes a new period in the middle of a cycle and checks that the counter still wraps at the old limit. A design that copies the period at once would wrap early and leave a short cycle. Two writes made before one boundary must leave only the second value. A staging write and a boundary in the same step must keep the new value pending, not lose it. Writes with either lock set, with junk in the upper data bits, with a zero period, with zero and oversized duty, with zero dividers and with the spare source codes each have their own reference trace. A design that decoded a wrong prescaler tap or mistimed the center-aligned turn-around would drift from that trace within a few steps.

// File: rtl/pwm_dbuf_pkg.sv
package pwm_dbuf_pkg;
  typedef enum logic [2:0] {
    ADDR_PER_STAGE = 3'd0,
    ADDR_DUTY      = 3'd1,
    ADDR_CFG       = 3'd2,
    ADDR_DIVA      = 3'd3,
    ADDR_DIVB      = 3'd4
  } reg_addr_e;

  localparam int unsigned SEL_W    = 4;
  localparam int unsigned SEL_DIVA = 11;
  localparam int unsigned SEL_DIVB = 12;
  localparam int unsigned CFG_CENTER_BIT = 4;
endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
  parameter int unsigned TAPS = 11
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  output logic [TAPS-1:0] tap_o
);
  localparam int unsigned CW = (TAPS > 1) ? TAPS - 1 : 1;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + 1'b1;

  // tap k fires once every 2^k cycles
  for (genvar k = 0; k < TAPS; k++) begin : g_tap
    if (k == 0) begin : g_t0
      assign tap_o[k] = 1'b1;
    end else begin : g_tk
      assign tap_o[k] = &cnt_q[k-1:0];
    end
  end
endmodule

// File: rtl/pwm_clk_div.sv
module pwm_clk_div #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  // >= keeps the divider from stalling when div_i shrinks below cnt_q
  assign tick_o = (div_i != '0) && (cnt_q >= div_i - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)              cnt_q <= '0;
    else if (div_i == '0)     cnt_q <= '0;
    else if (tick_o)          cnt_q <= '0;
    else                      cnt_q <= cnt_q + 1'b1;
endmodule

// File: rtl/pwm_dbuf_chan.sv
module pwm_dbuf_chan
  import pwm_dbuf_pkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned DIV_W  = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned TAPS   = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [2:0]        wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              wp_sw_i,
  input  logic              wp_hw_i,
  output logic              pwm_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              upd_o
);
  localparam int unsigned NSRC = 2 ** SEL_W;
  localparam int unsigned NDIV = 2;

  logic [CNT_W-1:0] per_stage_q, per_act_q, duty_q, cnt_q, cnt_d;
  logic             pend_q, up_q, up_d, upd_q;
  logic [SEL_W-1:0] sel_q;
  logic             center_q;
  logic [DIV_W-1:0] div_q [NDIV];
  logic [TAPS-1:0]  tap;
  logic [NDIV-1:0]  div_tick;
  logic [NSRC-1:0]  src_vec;
  logic             tick, boundary, apply, stage_wr;

  assign stage_wr = wr_en_i && (wr_addr_i == ADDR_PER_STAGE) && !wp_sw_i && !wp_hw_i;

  // register file
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      duty_q   <= '0;
      sel_q    <= '0;
      center_q <= 1'b0;
      div_q[0] <= '0;
      div_q[1] <= '0;
    end else if (wr_en_i) begin
      case (wr_addr_i)
        ADDR_DUTY: duty_q <= wr_data_i[CNT_W-1:0];
        ADDR_CFG: begin
          sel_q    <= wr_data_i[SEL_W-1:0];
          center_q <= wr_data_i[CFG_CENTER_BIT];
        end
        ADDR_DIVA: div_q[0] <= wr_data_i[DIV_W-1:0];
        ADDR_DIVB: div_q[1] <= wr_data_i[DIV_W-1:0];
        default: ;
      endcase
    end

  // step sources
  pwm_prescaler #(.TAPS(TAPS)) u_pre (.clk_i(clk_i), .rst_ni(rst_ni), .tap_o(tap));

  for (genvar d = 0; d < NDIV; d++) begin : g_div
    pwm_clk_div #(.DIV_W(DIV_W)) u_div (
      .clk_i(clk_i), .rst_ni(rst_ni), .div_i(div_q[d]), .tick_o(div_tick[d])
    );
  end

  always_comb begin
    src_vec           = '0;
    src_vec[TAPS-1:0] = tap;
    src_vec[SEL_DIVA] = div_tick[0];
    src_vec[SEL_DIVB] = div_tick[1];
  end
  assign tick = src_vec[sel_q];

  // counter
  always_comb begin
    cnt_d    = cnt_q;
    up_d     = up_q;
    boundary = 1'b0;
    if (tick) begin
      if (per_act_q == '0) begin
        cnt_d = '0; up_d = 1'b1; boundary = 1'b1;
      end else if (!center_q) begin
        if (cnt_q >= per_act_q - 1'b1) begin
          cnt_d = '0; boundary = 1'b1;
        end else cnt_d = cnt_q + 1'b1;
      end else if (up_q) begin
        if (cnt_q >= per_act_q - 1'b1) begin
          cnt_d = per_act_q; up_d = 1'b0;
        end else cnt_d = cnt_q + 1'b1;
      end else begin
        if (cnt_q <= CNT_W'(1)) begin
          cnt_d = '0; up_d = 1'b1; boundary = 1'b1;
        end else cnt_d = cnt_q - 1'b1;
      end
    end
  end

  assign apply = boundary && pend_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      cnt_q       <= '0;
      up_q        <= 1'b1;
      per_act_q   <= '0;
      per_stage_q <= '0;
      pend_q      <= 1'b0;
      upd_q       <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      up_q  <= up_d;
      upd_q <= apply;
      if (apply) per_act_q <= per_stage_q;
      // a write in the boundary step stays pending for the next cycle
      if (stage_wr) begin
        per_stage_q <= wr_data_i[CNT_W-1:0];
        pend_q      <= 1'b1;
      end else if (apply) begin
        pend_q <= 1'b0;
      end
    end

  assign cnt_o = cnt_q;
  assign upd_o = upd_q;
  assign pwm_o = (per_act_q != '0) && ((cnt_q < duty_q) || (duty_q >= per_act_q));
endmodule

// File: rtl/pwm_dbuf_chan_chk.sv
module pwm_dbuf_chan_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick,
  input logic             boundary,
  input logic [CNT_W-1:0] per_act,
  input logic [CNT_W-1:0] per_stage,
  input logic [CNT_W-1:0] cnt,
  input logic             upd,
  input logic             pwm,
  input logic             wr_en,
  input logic [2:0]       wr_addr,
  input logic             wp_sw,
  input logic             wp_hw
);
  // R1
  per_only_at_boundary_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(per_act) |-> $past(boundary));

  // R3
  locked_write_dropped_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(wr_en && wr_addr == 3'd0 && (wp_sw || wp_hw)) |-> $stable(per_stage));

  // R6
  cnt_within_period_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt <= per_act);

  // R4
  cnt_moves_on_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cnt) |-> $past(tick));

  // R10
  zero_period_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    per_act == '0 |-> (cnt == '0 && !pwm));

  // R11
  upd_carries_stage_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd |-> per_act == $past(per_stage));
endmodule

bind pwm_dbuf_chan pwm_dbuf_chan_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tick(tick), .boundary(boundary),
  .per_act(per_act_q), .per_stage(per_stage_q), .cnt(cnt_q), .upd(upd_o),
  .pwm(pwm_o), .wr_en(wr_en_i), .wr_addr(wr_addr_i), .wp_sw(wp_sw_i), .wp_hw(wp_hw_i)
);

// File: tb/pwm_dbuf_chan_tb.sv
module pwm_dbuf_chan_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        wp_sw = 1'b0, wp_hw = 1'b0;
  logic        pwm;
  logic [15:0] cnt;
  logic        upd;

  int errors = 0, checks = 0, upd_seen = 0;
  bit checking = 0, done = 0;
  string tag = "R12";

  // reference state
  int m_pre, m_dca, m_dcb, m_diva, m_divb, m_cfg, m_duty;
  int m_per, m_stage, m_cnt;
  bit m_pend, m_up, m_upd;

  always #2 clk = ~clk; // 250 MHz

  pwm_dbuf_chan u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .wp_sw_i(wp_sw), .wp_hw_i(wp_hw),
    .pwm_o(pwm), .cnt_o(cnt), .upd_o(upd)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pre = 0; m_dca = 0; m_dcb = 0; m_diva = 0; m_divb = 0; m_cfg = 0;
      m_duty = 0; m_per = 0; m_stage = 0; m_cnt = 0; m_pend = 0; m_up = 1; m_upd = 0;
    end else begin
      int sel;
      bit step, bnd;
      sel = m_cfg % 16;
      step = 0; bnd = 0;
      if (sel <= 10) step = ((m_pre % (1 << sel)) == (1 << sel) - 1);
      else if (sel == 11) step = (m_diva != 0) && (m_dca >= m_diva - 1);
      else if (sel == 12) step = (m_divb != 0) && (m_dcb >= m_divb - 1);
      m_pre = (m_pre + 1) % 1024;
      m_dca = (m_diva == 0 || m_dca >= m_diva - 1) ? 0 : m_dca + 1;
      m_dcb = (m_divb == 0 || m_dcb >= m_divb - 1) ? 0 : m_dcb + 1;
      if (step) begin
        if (m_per == 0) begin m_cnt = 0; m_up = 1; bnd = 1; end
        else if (!m_cfg[4]) begin
          if (m_cnt >= m_per - 1) begin m_cnt = 0; bnd = 1; end else m_cnt++;
        end else if (m_up) begin
          if (m_cnt >= m_per - 1) begin m_cnt = m_per; m_up = 0; end else m_cnt++;
        end else begin
          if (m_cnt <= 1) begin m_cnt = 0; m_up = 1; bnd = 1; end else m_cnt--;
        end
      end
      m_upd = bnd && m_pend;
      if (m_upd) begin m_per = m_stage; m_pend = 0; end
      if (wr_en) begin
        case (wr_addr)
          3'd0: if (!wp_sw && !wp_hw) begin m_stage = wr_data & 32'hFFFF; m_pend = 1; end
          3'd1: m_duty = wr_data & 32'hFFFF;
          3'd2: m_cfg = wr_data & 32'h1F;
          3'd3: m_diva = wr_data & 32'hFF;
          3'd4: m_divb = wr_data & 32'hFF;
          default: ;
        endcase
      end
    end
  end

  function automatic bit exp_pwm();
    return (m_per != 0) && (m_cnt < m_duty || m_duty >= m_per);
  endfunction

  task automatic check(bit ok, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act=%0d exp=%0d", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) if (checking && rst_n) begin
    check(cnt == m_cnt[15:0], "cnt", cnt, m_cnt);
    check(pwm == exp_pwm(), "pwm", pwm, exp_pwm());
    check(upd == m_upd, "upd", upd, m_upd);
    if (upd) upd_seen++;
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic run(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    tag = "watchdog";
    checks++; errors++;
    $display("FAIL watchdog expired act=1 exp=0");
    finish_up();
  end

  initial begin
    run(3);
    tag = "R12";
    check(cnt == 0, "reset cnt", cnt, 0);
    check(pwm == 0, "reset pwm", pwm, 0);
    check(upd == 0, "reset upd", upd, 0);
    rst_n = 1'b1;
    checking = 1;
    run(4);

    tag = "R2";
    wr(3'd1, 32'h0000_0003);
    wr(3'd0, 32'h1234_0005);
    run(30);

    tag = "R6";
    run(20);

    tag = "R1";
    wr(3'd0, 32'd8);
    run(3);
    tag = "R8";
    wr(3'd0, 32'd4);
    run(40);

    tag = "R3";
    upd_seen = 0;
    wp_sw = 1'b1; wr(3'd0, 32'd9); wp_sw = 1'b0;
    wp_hw = 1'b1; wr(3'd0, 32'd7); wp_hw = 1'b0;
    run(30);
    check(upd_seen == 0, "locked write applied", upd_seen, 0);

    tag = "R9";
    wr(3'd1, 32'd0);
    run(20);
    wr(3'd1, 32'hFFFF_000A);
    run(20);
    wr(3'd1, 32'd2);

    tag = "R4";
    wr(3'd2, 32'd2);
    run(100);
    wr(3'd2, 32'd10);
    run(5000);

    tag = "R10";
    wr(3'd2, 32'd0);
    wr(3'd0, 32'd0);
    run(20);

    tag = "R7";
    wr(3'd2, 32'h10);
    wr(3'd0, 32'd5);
    run(40);
    tag = "R8";
    wr(3'd0, 32'd3);
    run(30);

    tag = "R5";
    wr(3'd3, 32'd3);
    wr(3'd2, 32'h1B);
    run(120);
    wr(3'd4, 32'd5);
    wr(3'd2, 32'h0C);
    run(120);
    wr(3'd4, 32'd0);
    run(30);
    wr(3'd2, 32'h0D);
    run(30);

    tag = "R11";
    upd_seen = 0;
    wr(3'd2, 32'd0);
    wr(3'd0, 32'd6);
    run(30);
    check(upd_seen == 1, "update pulse count", upd_seen, 1);

    tag = "R10";
    wr(3'd0, 32'd0);
    run(20);
    check(pwm == 0 && cnt == 0, "zero period idle", {cnt, pwm}, 0);

    checking = 0;
    finish_up();
  end
endmodule